// File: doc/BRIEF.md
# Addressed Single-Wire Command Controller

This block is the command engine on the device side of a single-wire bus whose pulses have already been measured and sorted into four symbol classes: a short pulse (a zero bit, or a prompt when no command is open), a medium pulse (a one bit), a transaction pulse that frames every command, and a long initialization pulse. The engine reads these symbols one at a time, decodes the command sequences that select the device, give it an identity, load its 24-bit control word and read that word back, and drives the decoded per-channel controls of three video channels.

A host first gives each device on the bus a 4-bit identity with an initialization sequence; later it opens a device with an address sequence and then writes a new control word or pulls the current one out bit by bit with prompts. A lone device that has never been given an identity answers every write and prompt directly. New control data is gathered in a shadow shift register and reaches the live register only when the command is closed correctly, so a broken or short transfer never disturbs the channels.

Top module: `swb_cmd_ctrl`

## Requirements
- R1: After a synchronous active-low reset every byte of the control word is 8'b0110_0000 (0x606060 in total), no identity is held, the device is not selected and no read bit is flagged.
- R2: Symbol codes are 2'b00 short, 2'b01 one, 2'b10 transaction, 2'b11 init; a short pulse is bit 0 and a one pulse is bit 1. A command opens with a transaction pulse and three bits, first bit received being the MSB: 001 write, 010 address, 011 initialize; it closes with a transaction pulse followed by 111.
- R3: An initialize sequence (open 011, init pulse, 4 ID bits LSB first, close) sets the device identity; once an identity is held, further initialize sequences leave it unchanged until reset.
- R4: While no identity is held, writes are accepted and prompts are answered without any address sequence.
- R5: Once an identity is held, a closed address sequence (4 bits LSB first) selects the device if the address equals the identity and deselects it otherwise; an initialize sequence also leaves the device deselected. Writes and prompts are ignored while deselected.
- R6: A write needs at least 24 data bits, sent LSB first; with more, only the last 24 received are kept; with fewer, the control word is unchanged.
- R7: Write data reaches the control word only when the closing code is exactly 111; any other closing code discards it.
- R8: A short pulse outside any command, while the device is accessible, raises the read-valid strobe for one cycle in the cycle after the pulse, carrying the next control-word bit starting at bit 0 and wrapping to bit 0 after bit 23. The read position returns to bit 0 at each closed address sequence and each accepted write.
- R9: A symbol that does not fit the open sequence (for example an init pulse during write data, or a transaction pulse among the opcode bits) returns the engine to idle and drops the partial command.
- R10: Byte k of the control word (k = 0..2) drives channel k: bit 7 input select, bit 6 filter bypass, bit 5 clamp level, bits 4:3 boost code, bit 2 output disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | One-cycle strobe: a classified symbol is present |
| sym_code | input | 2 | Symbol class (00 short, 01 one, 10 transaction, 11 init) |
| ctrl_word | output | 24 | Live control word |
| dev_id | output | 4 | Assigned device identity |
| id_valid | output | 1 | An identity has been assigned |
| selected | output | 1 | Device opened by the last address sequence |
| rd_valid | output | 1 | Read bit strobe |
| rd_bit | output | 1 | Read data bit |
| ch_in_sel | output | 3 | Input select, one bit per channel |
| ch_bypass | output | 3 | Filter bypass, one bit per channel |
| ch_clamp | output | 3 | Clamp level, one bit per channel |
| ch_boost | output | 6 | Boost code, two bits per channel, channel 0 lowest |
| ch_out_dis | output | 3 | Output disable, one bit per channel |

## Verification
Writes are sent with lengths of 23, exactly 24 and beyond 24 bits, which separates the short-write rejection from a keep-first or keep-last error in the shadow. Bad closing codes and init pulses thrown into open write data tell a commit-on-close design from one that commits on the 24th bit. Address sequences that match and miss the identity, plus a repeated initialize, separate selection from broadcast access, and long prompt runs past 24 expose wrap and read-position reset faults; random write lengths and data then compare the full word and the channel fields against a bench model.

// File: rtl/swb_pkg.sv
// Package: shared symbol classes, command codes and engine states of the
// single-wire command controller. Assumes symbols arrive pre-classified.
package swb_pkg;
    typedef enum logic [1:0] {
        SYM_SHORT = 2'b00,
        SYM_ONE   = 2'b01,
        SYM_TRANS = 2'b10,
        SYM_INIT  = 2'b11
    } sym_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_INITW,
        ST_PAYLD,
        ST_ENDT,
        ST_CLOSE
    } st_e;

    typedef enum logic [1:0] {
        K_WR,
        K_ADDR,
        K_INIT
    } kind_e;

    localparam logic [2:0] OPC_WR   = 3'b001;
    localparam logic [2:0] OPC_ADDR = 3'b010;
    localparam logic [2:0] OPC_INIT = 3'b011;
    localparam logic [2:0] OPC_END  = 3'b111;
endpackage

// File: rtl/swb_seq_fsm.sv
// Sequence parser: walks the open/payload/close framing of each command and
// emits one-cycle strobes for payload bits, shadow clear, commits and prompts.
// Assumes at most one symbol per cycle, flagged by sym_valid.
module swb_seq_fsm
    import swb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic [1:0] sym_code,
    output logic       bit_en,
    output logic       bit_val,
    output logic       sh_clr,
    output logic       cmt_wr,
    output logic       cmt_addr,
    output logic       cmt_init,
    output logic       prompt
);
    localparam int CNT_W = $clog2(ADDR_W + 1);

    st_e              st_q, st_d;
    kind_e            kind_q, kind_d;
    logic [2:0]       code_q, code_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             is_bit;
    logic [2:0]       code_nx;
    sym_e             sym;

    assign sym     = sym_e'(sym_code);
    assign is_bit  = sym_valid && (sym == SYM_SHORT || sym == SYM_ONE);
    assign bit_val = (sym == SYM_ONE);
    assign code_nx = {code_q[1:0], bit_val};

    // Next-state and strobe decode for the current symbol.
    always_comb begin
        st_d     = st_q;
        kind_d   = kind_q;
        code_d   = code_q;
        cnt_d    = cnt_q;
        bit_en   = 1'b0;
        sh_clr   = 1'b0;
        cmt_wr   = 1'b0;
        cmt_addr = 1'b0;
        cmt_init = 1'b0;
        prompt   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (sym_valid && sym == SYM_TRANS) begin
                    st_d   = ST_OPC;
                    sh_clr = 1'b1;
                    cnt_d  = '0;
                end else if (sym_valid && sym == SYM_SHORT) begin
                    prompt = 1'b1;
                end
            end
            ST_OPC: begin
                if (is_bit) begin
                    code_d = code_nx;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(2)) begin
                        cnt_d = '0;
                        case (code_nx)
                            OPC_WR:   begin kind_d = K_WR;   st_d = ST_PAYLD; end
                            OPC_ADDR: begin kind_d = K_ADDR; st_d = ST_PAYLD; end
                            OPC_INIT: begin kind_d = K_INIT; st_d = ST_INITW; end
                            default:  st_d = ST_IDLE;
                        endcase
                    end
                end else if (sym_valid) begin
                    st_d = ST_IDLE;
                end
            end
            ST_INITW: begin
                if (sym_valid) st_d = (sym == SYM_INIT) ? ST_PAYLD : ST_IDLE;
            end
            ST_PAYLD: begin
                if (is_bit) begin
                    bit_en = 1'b1;
                    if (kind_q != K_WR) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(ADDR_W - 1)) st_d = ST_ENDT;
                    end
                end else if (sym_valid) begin
                    if (sym == SYM_TRANS && kind_q == K_WR) begin
                        st_d  = ST_CLOSE;
                        cnt_d = '0;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            ST_ENDT: begin
                if (sym_valid) begin
                    st_d  = (sym == SYM_TRANS) ? ST_CLOSE : ST_IDLE;
                    cnt_d = '0;
                end
            end
            ST_CLOSE: begin
                if (is_bit) begin
                    code_d = code_nx;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(2)) begin
                        st_d = ST_IDLE;
                        if (code_nx == OPC_END) begin
                            cmt_wr   = (kind_q == K_WR);
                            cmt_addr = (kind_q == K_ADDR);
                            cmt_init = (kind_q == K_INIT);
                        end
                    end
                end else if (sym_valid) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, command kind, code and bit-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= K_WR;
            code_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            code_q <= code_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/swb_shadow.sv
// Shadow shift register: payload bits enter at the MSB and move toward the
// LSB, so the last REG_W bits sent LSB first end up in place. A saturating
// fill count reports when at least REG_W bits have arrived since the clear.
module swb_shadow #(
    parameter int REG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    output logic [REG_W-1:0] data,
    output logic             full
);
    localparam int FILL_W = $clog2(REG_W + 1);

    logic [FILL_W-1:0] fill_q;

    assign full = (fill_q == FILL_W'(REG_W));

    // Shift data in and count bits, saturating at REG_W.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data   <= '0;
            fill_q <= '0;
        end else if (shift_en) begin
            data <= {din, data[REG_W-1:1]};
            if (!full) fill_q <= fill_q + 1'b1;
        end
    end
endmodule

// File: rtl/swb_reg_bank.sv
// Live control word with its read pointer and per-channel field decode.
// Assumes load and read never coincide (the parser guarantees it).
module swb_reg_bank #(
    parameter int CH_N = 3,
    parameter logic [7:0] CH_RST = 8'b0110_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [8*CH_N-1:0] load_data,
    input  logic              ptr_rst,
    input  logic              rd_req,
    output logic [8*CH_N-1:0] word,
    output logic              rd_valid,
    output logic              rd_bit,
    output logic [CH_N-1:0]   in_sel,
    output logic [CH_N-1:0]   bypass,
    output logic [CH_N-1:0]   clamp,
    output logic [2*CH_N-1:0] boost,
    output logic [CH_N-1:0]   out_dis
);
    localparam int REG_W = 8 * CH_N;
    localparam int PTR_W = $clog2(REG_W);

    logic [PTR_W-1:0] ptr_q;

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)    word <= {CH_N{CH_RST}};
        else if (load) word <= load_data;
    end

    // Read pointer and registered read bit with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            rd_valid <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (ptr_rst) begin
                ptr_q <= '0;
            end else if (rd_req) begin
                rd_bit <= word[ptr_q];
                ptr_q  <= (ptr_q == PTR_W'(REG_W - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // One field decoder per channel byte.
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign in_sel[c]       = word[8*c + 7];
        assign bypass[c]       = word[8*c + 6];
        assign clamp[c]        = word[8*c + 5];
        assign boost[2*c +: 2] = word[8*c + 3 +: 2];
        assign out_dis[c]      = word[8*c + 2];
    end
endmodule

// File: rtl/swb_cmd_ctrl.sv
// Top of the single-wire command controller: parser, shadow and control
// word, plus the identity and selection state that gate access.
// Assumes symbols are classified upstream; read data leaves as bit+strobe.
module swb_cmd_ctrl #(
    parameter int CH_N   = 3,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sym_valid,
    input  logic [1:0]          sym_code,
    output logic [8*CH_N-1:0]   ctrl_word,
    output logic [ADDR_W-1:0]   dev_id,
    output logic                id_valid,
    output logic                selected,
    output logic                rd_valid,
    output logic                rd_bit,
    output logic [CH_N-1:0]     ch_in_sel,
    output logic [CH_N-1:0]     ch_bypass,
    output logic [CH_N-1:0]     ch_clamp,
    output logic [2*CH_N-1:0]   ch_boost,
    output logic [CH_N-1:0]     ch_out_dis
);
    localparam int REG_W = 8 * CH_N;

    logic             bit_en, bit_val, sh_clr, cmt_wr, cmt_addr, cmt_init, prompt;
    logic [REG_W-1:0] sh_data;
    logic             sh_full;
    logic             access;
    logic [ADDR_W-1:0] rx_addr;

    assign access  = selected || !id_valid;
    assign rx_addr = sh_data[REG_W-1 -: ADDR_W];

    swb_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .bit_en(bit_en), .bit_val(bit_val), .sh_clr(sh_clr),
        .cmt_wr(cmt_wr), .cmt_addr(cmt_addr), .cmt_init(cmt_init),
        .prompt(prompt)
    );

    swb_shadow #(.REG_W(REG_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(bit_en),
        .din(bit_val), .data(sh_data), .full(sh_full)
    );

    swb_reg_bank #(.CH_N(CH_N)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .load(cmt_wr && sh_full && access), .load_data(sh_data),
        .ptr_rst(cmt_addr || (cmt_wr && sh_full && access)),
        .rd_req(prompt && access),
        .word(ctrl_word), .rd_valid(rd_valid), .rd_bit(rd_bit),
        .in_sel(ch_in_sel), .bypass(ch_bypass), .clamp(ch_clamp),
        .boost(ch_boost), .out_dis(ch_out_dis)
    );

    // Identity assignment (once per reset) and address selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_id   <= '0;
            id_valid <= 1'b0;
            selected <= 1'b0;
        end else if (cmt_init) begin
            selected <= 1'b0;
            if (!id_valid) begin
                dev_id   <= rx_addr;
                id_valid <= 1'b1;
            end
        end else if (cmt_addr) begin
            selected <= id_valid && (rx_addr == dev_id);
        end
    end
endmodule

// File: rtl/swb_cmd_ctrl_chk.sv
// Checker for swb_cmd_ctrl: protocol-level properties over its ports.
module swb_cmd_ctrl_chk #(
    parameter int CH_N   = 3,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sym_valid,
    input logic [1:0]          sym_code,
    input logic [8*CH_N-1:0]   ctrl_word,
    input logic [ADDR_W-1:0]   dev_id,
    input logic                id_valid,
    input logic                selected,
    input logic                rd_valid
);
    a_r1_reset_word: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_word == {CH_N{8'b0110_0000}} && !id_valid && !selected));

    a_r3_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && $past(id_valid)) |-> $stable(dev_id));

    a_r5_sel_needs_id: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> id_valid);

    a_r7_commit_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(ctrl_word)) |-> $past(sym_valid && sym_code == 2'b01));

    a_r8_read_after_short: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(sym_valid && sym_code == 2'b00));
endmodule

bind swb_cmd_ctrl swb_cmd_ctrl_chk #(.CH_N(CH_N), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
    .ctrl_word(ctrl_word), .dev_id(dev_id), .id_valid(id_valid),
    .selected(selected), .rd_valid(rd_valid)
);

// File: tb/swb_cmd_ctrl_bench.sv
module swb_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym_code = 2'b00;
    logic [23:0] ctrl_word;
    logic [3:0]  dev_id;
    logic        id_valid, selected, rd_valid, rd_bit;
    logic [2:0]  ch_in_sel, ch_bypass, ch_clamp, ch_out_dis;
    logic [5:0]  ch_boost;

    int total = 0;
    int bad = 0;

    // bench model
    logic [23:0] m_word;
    logic [3:0]  m_id;
    logic        m_idv, m_sel;
    int          m_ptr;

    always #10 clk = ~clk;

    swb_cmd_ctrl u_swb_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .ctrl_word(ctrl_word), .dev_id(dev_id), .id_valid(id_valid),
        .selected(selected), .rd_valid(rd_valid), .rd_bit(rd_bit),
        .ch_in_sel(ch_in_sel), .ch_bypass(ch_bypass), .ch_clamp(ch_clamp),
        .ch_boost(ch_boost), .ch_out_dis(ch_out_dis)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sym(input logic [1:0] c);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = c;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic bits(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) sym(v[i] ? 2'b01 : 2'b00);
    endtask

    task automatic open_cmd(input logic [2:0] op);
        sym(2'b10);
        for (int i = 2; i >= 0; i--) sym(op[i] ? 2'b01 : 2'b00);
    endtask

    task automatic close_cmd(input logic [2:0] cl);
        sym(2'b10);
        for (int i = 2; i >= 0; i--) sym(cl[i] ? 2'b01 : 2'b00);
    endtask

    function automatic logic acc();
        return m_sel || !m_idv;
    endfunction

    task automatic do_write(input logic [63:0] v, input int n, input logic [2:0] cl);
        open_cmd(3'b001);
        bits(v, n);
        close_cmd(cl);
        if (cl == 3'b111 && n >= 24 && acc()) begin
            m_word = v[n-24 +: 24];
            m_ptr  = 0;
        end
    endtask

    task automatic do_addr(input logic [3:0] a);
        open_cmd(3'b010);
        bits({60'd0, a}, 4);
        close_cmd(3'b111);
        m_sel = m_idv && (a == m_id);
        m_ptr = 0;
    endtask

    task automatic do_init(input logic [3:0] a);
        open_cmd(3'b011);
        sym(2'b11);
        bits({60'd0, a}, 4);
        close_cmd(3'b111);
        if (!m_idv) begin m_id = a; m_idv = 1'b1; end
        m_sel = 1'b0;
    endtask

    // one prompt, checks the strobe and bit against the model
    task automatic prompt_chk(input string req);
        sym(2'b00);
        chk(req, {31'd0, rd_valid}, {31'd0, acc()});
        if (acc()) begin
            chk(req, {31'd0, rd_bit}, {31'd0, m_word[m_ptr]});
            m_ptr = (m_ptr == 23) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic check_state(input string req);
        chk(req, {8'd0, ctrl_word}, {8'd0, m_word});
        chk(req, {27'd0, selected, id_valid, dev_id[2:0] & {3{id_valid}}},
                 {27'd0, m_sel, m_idv, m_id[2:0] & {3{m_idv}}});
    endtask

    task automatic check_fields();
        for (int c = 0; c < 3; c++) begin
            chk("R10 in_sel",  {31'd0, ch_in_sel[c]},  {31'd0, m_word[8*c+7]});
            chk("R10 bypass",  {31'd0, ch_bypass[c]},  {31'd0, m_word[8*c+6]});
            chk("R10 clamp",   {31'd0, ch_clamp[c]},   {31'd0, m_word[8*c+5]});
            chk("R10 boost",   {30'd0, ch_boost[2*c +: 2]}, {30'd0, m_word[8*c+3 +: 2]});
            chk("R10 out_dis", {31'd0, ch_out_dis[c]}, {31'd0, m_word[8*c+2]});
        end
    endtask

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(1234));
        m_word = 24'h606060; m_id = 0; m_idv = 0; m_sel = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 word", {8'd0, ctrl_word}, 32'h00606060);
        chk("R1 flags", {29'd0, id_valid, selected, rd_valid}, 32'd0);
        check_fields();

        // R4 broadcast write of exactly 24 bits, then read back
        do_write(64'h00A5_C3F1, 24, 3'b111);
        check_state("R4 R2 broadcast write");
        for (int i = 0; i < 6; i++) prompt_chk("R4 R8 broadcast read");

        // R6 short write keeps old word
        do_write(64'h0012_3456, 23, 3'b111);
        check_state("R6 short write ignored");
        // R6 long write keeps the last 24 bits
        do_write(64'h2F_ABCD_EF13, 40, 3'b111);
        check_state("R6 long write last 24");
        // R7 wrong closing code
        do_write(64'h0077_7777, 24, 3'b110);
        check_state("R7 bad close discarded");
        // R9 init pulse inside write data aborts
        open_cmd(3'b001);
        bits(64'h0011_1111, 12);
        sym(2'b11);
        bits(64'h0011_1111, 12);
        close_cmd(3'b111);
        check_state("R9 abort write");
        // R9 transaction among opcode bits aborts; then unknown opcode
        sym(2'b10); sym(2'b00); sym(2'b10); sym(2'b01);
        open_cmd(3'b101);
        check_state("R9 abort opcode");

        // R3 initialize, then a second init is ignored
        do_init(4'd5);
        chk("R3 id", {27'd0, id_valid, dev_id}, {27'd1, 4'd5});
        do_init(4'd9);
        chk("R3 id once", {27'd0, id_valid, dev_id}, {27'd1, 4'd5});
        // R5 deselected: write and prompt ignored
        do_write(64'h00DE_ADBE, 24, 3'b111);
        check_state("R5 write ignored after init");
        prompt_chk("R5 prompt ignored");
        do_addr(4'd3);
        check_state("R5 miss");
        do_write(64'h00DE_ADBE, 24, 3'b111);
        check_state("R5 miss write ignored");
        do_addr(4'd5);
        check_state("R5 match");
        // R8 wrap: 30 prompts
        for (int i = 0; i < 30; i++) prompt_chk("R8 wrap read");
        do_addr(4'd5);
        for (int i = 0; i < 3; i++) prompt_chk("R8 pointer reset");

        // random writes, reads and selections
        for (int it = 0; it < 40; it++) begin
            int n;
            n = 20 + int'($urandom % 30);
            d = {$urandom, $urandom};
            if ($urandom % 5 == 0) do_addr(($urandom % 3 == 0) ? 4'(m_id + 1) : m_id);
            do_write(d, n, ($urandom % 6 == 0) ? 3'b011 : 3'b111);
            check_state("R6 R7 random write");
            for (int k = 0; k < int'($urandom % 8); k++) prompt_chk("R8 random read");
        end
        check_fields();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule